// File: doc/BRIEF.md
# AXI Command Packet Field Encoder

This block turns one AXI address-channel request, read or write, into the header of a command packet for an on-chip interconnect. Most request fields are copied unchanged: address, size, cache, protection, exclusive flag, thread ID and the user sideband. Two fields are computed while the request is taken in. The first is a run-time burstwrap mask derived from the burst type. The second is the total byte count of the burst.

Each request port has one instance. It sits between the AXI address channel and the packet network. A single output register holds the header, and a valid/ready pair drives that register. The address decoder supplies the destination ID. The source ID is fixed for the port by a parameter. A per-request flag marks writes that need a response, and the block turns that flag into the packet's posted bit.

Top module: `axi_cmd_encoder`

## Requirements
- R1: `req_ready` is high exactly when the header register is empty or `pkt_ready` is high in the same cycle. A request taken with `req_valid && req_ready` appears on the packet outputs, with `pkt_valid` high, on the next clock.
- R2: While `pkt_valid` is high and `pkt_ready` is low, `pkt_valid` stays high, every packet output holds its value, and `req_ready` is low.
- R3: For burst code 2'b01 (incrementing) and the reserved code 2'b11, `pkt_burstwrap` is all ones across its full width.
- R4: For burst code 2'b10 (wrapping), `pkt_burstwrap` = (`req_len`+1) × 2^`req_size` − 1. It saturates to all ones if that value does not fit the field.
- R5: For burst code 2'b00 (fixed), `pkt_burstwrap` = 2^`req_size` − 1.
- R6: `pkt_bytecnt` = (`req_len`+1) × 2^`req_size`, and `pkt_size` equals `req_size`.
- R7: The following outputs equal the request values: `pkt_addr`, `pkt_cache`, `pkt_tid`, `pkt_user` and `pkt_prot`. In `pkt_prot`, bit 0 set means privileged and bit 0 clear means normal. `pkt_dst` equals `req_dst`, and `pkt_src` equals the parameter `SRC_ID`.
- R8: With `QOS_EN`=1, `pkt_qos` equals `req_qos`. With `QOS_EN`=0, `pkt_qos` is always 4'b0000.
- R9: `pkt_excl` equals `req_lock`. `pkt_posted` is the inverse of `req_wr_resp`, so a write that needs a response is not posted.
- R10: During and right after synchronous reset, `pkt_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | 8 | Beats minus one |
| req_size | input | 3 | log2 of bytes per beat |
| req_burst | input | 2 | Burst type code |
| req_cache | input | 4 | Cache attributes |
| req_prot | input | 3 | Protection attributes |
| req_qos | input | 4 | Quality-of-service level |
| req_lock | input | 1 | Exclusive access |
| req_id | input | ID_W | Transaction ID |
| req_user | input | USER_W | Address sideband |
| req_wr_resp | input | 1 | Write that needs a response |
| req_dst | input | PORT_W | Destination ID from the address decode |
| pkt_valid | output | 1 | Header present |
| pkt_ready | input | 1 | Header consumed |
| pkt_addr | output | ADDR_W | Address field |
| pkt_size | output | 3 | Per-beat size field |
| pkt_burstwrap | output | BWRAP_W | Wrap mask |
| pkt_bytecnt | output | BCNT_W | Total bytes of the burst |
| pkt_cache | output | 4 | Cache field |
| pkt_prot | output | 3 | Protection field |
| pkt_qos | output | 4 | QoS field |
| pkt_excl | output | 1 | Exclusive flag |
| pkt_posted | output | 1 | Posted flag |
| pkt_tid | output | ID_W | Thread ID |
| pkt_src | output | PORT_W | Source ID |
| pkt_dst | output | PORT_W | Destination ID |
| pkt_user | output | USER_W | Address sideband field |

## Verification
The mask-shape property (every `pkt_burstwrap` of the form 2^n − 1) assumes wrapping requests are legal, with lengths of 2, 4, 8 or 16 beats. The stimulus picks wrap lengths only from that set and draws any size for the other burst types. No property requires request fields to stay stable while a request waits. The stimulus therefore changes them freely every cycle, and `pkt_ready` drops at random, including long low stretches that exercise the hold behaviour.

// File: rtl/cmdenc_pkg.sv
package cmdenc_pkg;

    localparam int LEN_W  = 8;
    localparam int SIZE_W = 3;
    // largest burst: 2^LEN_W beats of 2^(2^SIZE_W - 1) bytes
    localparam int BCNT_W = LEN_W + (2 ** SIZE_W);

    typedef enum logic [1:0] {
        BT_FIXED = 2'b00,
        BT_INCR  = 2'b01,
        BT_WRAP  = 2'b10,
        BT_RSVD  = 2'b11
    } burst_e;

    function automatic logic [BCNT_W-1:0] beat_span(input logic [SIZE_W-1:0] sz);
        return BCNT_W'(1) << sz;
    endfunction

endpackage

// File: rtl/cmdenc_bytecount.sv
module cmdenc_bytecount
    import cmdenc_pkg::*;
(
    input  logic [LEN_W-1:0]  len,
    input  logic [SIZE_W-1:0] size,
    output logic [BCNT_W-1:0] bytecnt
);
    logic [BCNT_W-1:0] beats;

    assign beats   = BCNT_W'(len) + BCNT_W'(1);
    assign bytecnt = beats << size;

endmodule

// File: rtl/cmdenc_burstwrap.sv
module cmdenc_burstwrap
    import cmdenc_pkg::*;
#(
    parameter int BWRAP_W = 12
) (
    input  logic [1:0]         burst,
    input  logic [SIZE_W-1:0]  size,
    input  logic [BCNT_W-1:0]  bytecnt,
    output logic [BWRAP_W-1:0] burstwrap
);
    logic [BCNT_W-1:0] span_m1;
    logic              seq;

    always_comb begin
        seq = 1'b0;
        unique case (burst_e'(burst))
            BT_FIXED: span_m1 = beat_span(size) - BCNT_W'(1);
            BT_WRAP:  span_m1 = bytecnt - BCNT_W'(1);
            default: begin
                span_m1 = '1;
                seq     = 1'b1;
            end
        endcase
    end

    generate
        if (BWRAP_W >= BCNT_W) begin : g_wide
            assign burstwrap = seq ? '1 : BWRAP_W'(span_m1);
        end else begin : g_narrow
            logic ovf;
            assign ovf       = |span_m1[BCNT_W-1:BWRAP_W];
            assign burstwrap = (seq || ovf) ? '1 : span_m1[BWRAP_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/cmdenc_hdr_reg.sv
module cmdenc_hdr_reg #(
    parameter type hdr_t = logic
) (
    input  logic clk,
    input  logic rst,
    input  logic ld_valid,
    output logic ld_ready,
    input  hdr_t ld_data,
    output logic out_valid,
    input  logic out_ready,
    output hdr_t out_data
);
    assign ld_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (ld_valid && ld_ready) begin
            out_valid <= 1'b1;
            out_data  <= ld_data;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/axi_cmd_encoder.sv
module axi_cmd_encoder
    import cmdenc_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ID_W    = 4,
    parameter int USER_W  = 8,
    parameter int PORT_W  = 4,
    parameter int BWRAP_W = 12,
    parameter int SRC_ID  = 3,
    parameter bit QOS_EN  = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [LEN_W-1:0]   req_len,
    input  logic [SIZE_W-1:0]  req_size,
    input  logic [1:0]         req_burst,
    input  logic [3:0]         req_cache,
    input  logic [2:0]         req_prot,
    input  logic [3:0]         req_qos,
    input  logic               req_lock,
    input  logic [ID_W-1:0]    req_id,
    input  logic [USER_W-1:0]  req_user,
    input  logic               req_wr_resp,
    input  logic [PORT_W-1:0]  req_dst,
    output logic               pkt_valid,
    input  logic               pkt_ready,
    output logic [ADDR_W-1:0]  pkt_addr,
    output logic [SIZE_W-1:0]  pkt_size,
    output logic [BWRAP_W-1:0] pkt_burstwrap,
    output logic [BCNT_W-1:0]  pkt_bytecnt,
    output logic [3:0]         pkt_cache,
    output logic [2:0]         pkt_prot,
    output logic [3:0]         pkt_qos,
    output logic               pkt_excl,
    output logic               pkt_posted,
    output logic [ID_W-1:0]    pkt_tid,
    output logic [PORT_W-1:0]  pkt_src,
    output logic [PORT_W-1:0]  pkt_dst,
    output logic [USER_W-1:0]  pkt_user
);
    localparam logic [PORT_W-1:0] SRC_CODE = PORT_W'(SRC_ID);

    typedef struct packed {
        logic [ADDR_W-1:0]  addr;
        logic [SIZE_W-1:0]  size;
        logic [BWRAP_W-1:0] bwrap;
        logic [BCNT_W-1:0]  bcnt;
        logic [3:0]         cache;
        logic [2:0]         prot;
        logic [3:0]         qos;
        logic               excl;
        logic               posted;
        logic [ID_W-1:0]    tid;
        logic [PORT_W-1:0]  src;
        logic [PORT_W-1:0]  dst;
        logic [USER_W-1:0]  user;
    } hdr_t;

    logic [BCNT_W-1:0]  bcnt_c;
    logic [BWRAP_W-1:0] bwrap_c;
    logic [3:0]         qos_c;
    hdr_t               hdr_in;
    hdr_t               hdr_q;

    cmdenc_bytecount u_bcnt (
        .len     (req_len),
        .size    (req_size),
        .bytecnt (bcnt_c)
    );

    cmdenc_burstwrap #(.BWRAP_W(BWRAP_W)) u_bwrap (
        .burst     (req_burst),
        .size      (req_size),
        .bytecnt   (bcnt_c),
        .burstwrap (bwrap_c)
    );

    generate
        if (QOS_EN) begin : g_qos
            assign qos_c = req_qos;
        end else begin : g_noqos
            logic [3:0] qos_unused;
            assign qos_unused = req_qos;
            assign qos_c      = 4'b0000 & qos_unused;
        end
    endgenerate

    always_comb begin
        hdr_in.addr   = req_addr;
        hdr_in.size   = req_size;
        hdr_in.bwrap  = bwrap_c;
        hdr_in.bcnt   = bcnt_c;
        hdr_in.cache  = req_cache;
        hdr_in.prot   = req_prot;
        hdr_in.qos    = qos_c;
        hdr_in.excl   = req_lock;
        hdr_in.posted = !req_wr_resp;
        hdr_in.tid    = req_id;
        hdr_in.src    = SRC_CODE;
        hdr_in.dst    = req_dst;
        hdr_in.user   = req_user;
    end

    cmdenc_hdr_reg #(.hdr_t(hdr_t)) u_hreg (
        .clk       (clk),
        .rst       (rst),
        .ld_valid  (req_valid),
        .ld_ready  (req_ready),
        .ld_data   (hdr_in),
        .out_valid (pkt_valid),
        .out_ready (pkt_ready),
        .out_data  (hdr_q)
    );

    assign pkt_addr      = hdr_q.addr;
    assign pkt_size      = hdr_q.size;
    assign pkt_burstwrap = hdr_q.bwrap;
    assign pkt_bytecnt   = hdr_q.bcnt;
    assign pkt_cache     = hdr_q.cache;
    assign pkt_prot      = hdr_q.prot;
    assign pkt_qos       = hdr_q.qos;
    assign pkt_excl      = hdr_q.excl;
    assign pkt_posted    = hdr_q.posted;
    assign pkt_tid       = hdr_q.tid;
    assign pkt_src       = hdr_q.src;
    assign pkt_dst       = hdr_q.dst;
    assign pkt_user      = hdr_q.user;

endmodule

// File: rtl/cmdenc_checker.sv
module cmdenc_checker #(
    parameter int ADDR_W  = 32,
    parameter int BWRAP_W = 12,
    parameter int BCNT_W  = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_ready,
    input logic [ADDR_W-1:0]  req_addr,
    input logic [1:0]         req_burst,
    input logic               req_lock,
    input logic               req_wr_resp,
    input logic               pkt_valid,
    input logic               pkt_ready,
    input logic [ADDR_W-1:0]  pkt_addr,
    input logic [BWRAP_W-1:0] pkt_burstwrap,
    input logic [BCNT_W-1:0]  pkt_bytecnt,
    input logic               pkt_excl,
    input logic               pkt_posted
);
    AST_BLOCK_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !pkt_ready) |-> !req_ready); // R2

    AST_HOLD_HEADER: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_addr)
            && $stable(pkt_burstwrap) && $stable(pkt_bytecnt))); // R2

    AST_ACCEPT_LOADS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (pkt_valid && pkt_addr == $past(req_addr))); // R1

    AST_EMPTY_READY: assert property (@(posedge clk) disable iff (rst)
        !pkt_valid |-> req_ready); // R1

    AST_SEQ_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_burst[0]) |=> (&pkt_burstwrap)); // R3

    AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |-> ((pkt_burstwrap & (pkt_burstwrap + 1'b1)) == '0)); // R4

    AST_BYTECNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |-> (pkt_bytecnt != '0)); // R6

    AST_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (pkt_excl == $past(req_lock)
            && pkt_posted == !$past(req_wr_resp))); // R9

endmodule

bind axi_cmd_encoder cmdenc_checker #(
    .ADDR_W (ADDR_W),
    .BWRAP_W(BWRAP_W),
    .BCNT_W (cmdenc_pkg::BCNT_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_addr     (req_addr),
    .req_burst    (req_burst),
    .req_lock     (req_lock),
    .req_wr_resp  (req_wr_resp),
    .pkt_valid    (pkt_valid),
    .pkt_ready    (pkt_ready),
    .pkt_addr     (pkt_addr),
    .pkt_burstwrap(pkt_burstwrap),
    .pkt_bytecnt  (pkt_bytecnt),
    .pkt_excl     (pkt_excl),
    .pkt_posted   (pkt_posted)
);

// File: tb/axi_cmd_encoder_bench.sv
`timescale 1ns/1ps
module axi_cmd_encoder_bench;
    localparam int AW = 32, IW = 4, UW = 8, PW = 4, BWW = 12, BCW = 16, SRC = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          req_valid = 0, req_lock = 0, req_wr_resp = 0, pkt_ready = 0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_len = '0;
    logic [2:0]    req_size = '0, req_prot = '0;
    logic [1:0]    req_burst = '0;
    logic [3:0]    req_cache = '0, req_qos = '0;
    logic [IW-1:0] req_id = '0;
    logic [UW-1:0] req_user = '0;
    logic [PW-1:0] req_dst = '0;

    logic           req_ready, pkt_valid, pkt_excl, pkt_posted;
    logic [AW-1:0]  pkt_addr;
    logic [2:0]     pkt_size, pkt_prot;
    logic [BWW-1:0] pkt_burstwrap;
    logic [BCW-1:0] pkt_bytecnt;
    logic [3:0]     pkt_cache, pkt_qos;
    logic [IW-1:0]  pkt_tid;
    logic [PW-1:0]  pkt_src, pkt_dst;
    logic [UW-1:0]  pkt_user;

    logic           n_ready, n_valid, n_excl, n_posted;
    logic [AW-1:0]  n_addr;
    logic [2:0]     n_size, n_prot;
    logic [BWW-1:0] n_bwrap;
    logic [BCW-1:0] n_bcnt;
    logic [3:0]     n_cache, n_qos;
    logic [IW-1:0]  n_tid;
    logic [PW-1:0]  n_src, n_dst;
    logic [UW-1:0]  n_user;

    axi_cmd_encoder u_axi_cmd_encoder (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_size(req_size),
        .req_burst(req_burst), .req_cache(req_cache), .req_prot(req_prot),
        .req_qos(req_qos), .req_lock(req_lock), .req_id(req_id),
        .req_user(req_user), .req_wr_resp(req_wr_resp), .req_dst(req_dst),
        .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_addr(pkt_addr),
        .pkt_size(pkt_size), .pkt_burstwrap(pkt_burstwrap),
        .pkt_bytecnt(pkt_bytecnt), .pkt_cache(pkt_cache), .pkt_prot(pkt_prot),
        .pkt_qos(pkt_qos), .pkt_excl(pkt_excl), .pkt_posted(pkt_posted),
        .pkt_tid(pkt_tid), .pkt_src(pkt_src), .pkt_dst(pkt_dst),
        .pkt_user(pkt_user));

    axi_cmd_encoder #(.QOS_EN(1'b0)) u_axi_cmd_encoder_noqos (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(n_ready),
        .req_addr(req_addr), .req_len(req_len), .req_size(req_size),
        .req_burst(req_burst), .req_cache(req_cache), .req_prot(req_prot),
        .req_qos(req_qos), .req_lock(req_lock), .req_id(req_id),
        .req_user(req_user), .req_wr_resp(req_wr_resp), .req_dst(req_dst),
        .pkt_valid(n_valid), .pkt_ready(pkt_ready), .pkt_addr(n_addr),
        .pkt_size(n_size), .pkt_burstwrap(n_bwrap), .pkt_bytecnt(n_bcnt),
        .pkt_cache(n_cache), .pkt_prot(n_prot), .pkt_qos(n_qos),
        .pkt_excl(n_excl), .pkt_posted(n_posted), .pkt_tid(n_tid),
        .pkt_src(n_src), .pkt_dst(n_dst), .pkt_user(n_user));

    int checks = 0, failures = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // reference model: one-entry header store
    bit      m_valid = 0;
    longint  e_addr, e_size, e_bwrap, e_bcnt, e_cache, e_prot, e_qos;
    longint  e_excl, e_posted, e_tid, e_dst, e_user;

    always @(posedge clk) begin
        if (rst) begin
            m_valid = 0;
        end else if (req_valid && (!m_valid || pkt_ready)) begin
            longint span, full;
            m_valid  = 1;
            full     = (longint'(1) << BWW) - 1;
            span     = longint'(1) << req_size;
            e_bcnt   = (longint'(req_len) + 1) * span;
            case (req_burst)
                2'b00:   e_bwrap = span - 1;
                2'b10:   e_bwrap = (e_bcnt - 1 > full) ? full : e_bcnt - 1;
                default: e_bwrap = full;
            endcase
            e_addr = req_addr; e_size = req_size; e_cache = req_cache;
            e_prot = req_prot; e_qos = req_qos; e_excl = req_lock;
            e_posted = !req_wr_resp; e_tid = req_id; e_dst = req_dst; e_user = req_user;
        end else if (pkt_ready) begin
            m_valid = 0;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            if (rst) begin
                chk(pkt_valid == 0, "R10 valid in reset", pkt_valid, 0);
            end else begin
                chk(req_ready == (!m_valid || pkt_ready), "R1/R2 req_ready", req_ready, !m_valid || pkt_ready);
                chk(pkt_valid == m_valid, "R1/R2 pkt_valid", pkt_valid, m_valid);
                chk(n_qos == 0, "R8 qos disabled", n_qos, 0);
                if (m_valid) begin
                    chk(pkt_burstwrap == e_bwrap, "R3/R4/R5 burstwrap", pkt_burstwrap, e_bwrap);
                    chk(pkt_bytecnt == e_bcnt, "R6 bytecnt", pkt_bytecnt, e_bcnt);
                    chk(pkt_size == e_size, "R6 size", pkt_size, e_size);
                    chk(pkt_addr == e_addr, "R7 addr", pkt_addr, e_addr);
                    chk(pkt_cache == e_cache, "R7 cache", pkt_cache, e_cache);
                    chk(pkt_prot == e_prot, "R7 prot", pkt_prot, e_prot);
                    chk(pkt_tid == e_tid, "R7 tid", pkt_tid, e_tid);
                    chk(pkt_user == e_user, "R7 user", pkt_user, e_user);
                    chk(pkt_dst == e_dst, "R7 dst", pkt_dst, e_dst);
                    chk(pkt_src == SRC, "R7 src", pkt_src, SRC);
                    chk(pkt_qos == e_qos, "R8 qos enabled", pkt_qos, e_qos);
                    chk(pkt_excl == e_excl, "R9 excl", pkt_excl, e_excl);
                    chk(pkt_posted == e_posted, "R9 posted", pkt_posted, e_posted);
                end
            end
        end
    end

    task automatic put(input bit v, input logic [1:0] bt, input logic [7:0] ln,
                       input logic [2:0] sz, input bit rdy);
        @(posedge clk); #1;
        req_valid = v; req_burst = bt; req_len = ln; req_size = sz; pkt_ready = rdy;
        req_addr = $urandom; req_cache = 4'($urandom); req_prot = 3'($urandom);
        req_qos = 4'($urandom); req_lock = 1'($urandom); req_id = IW'($urandom);
        req_user = UW'($urandom); req_wr_resp = 1'($urandom); req_dst = PW'($urandom);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R10: ready high straight after reset
        @(negedge clk);
        chk(req_ready == 1, "R10 ready after reset", req_ready, 1);
        // directed corners
        put(1, 2'b01, 8'd3,   3'd2, 1);  // R3 incr
        put(1, 2'b10, 8'd3,   3'd2, 1);  // R4 wrap 16 bytes -> 15
        put(1, 2'b00, 8'd9,   3'd3, 1);  // R5 fixed -> 7
        put(1, 2'b10, 8'd15,  3'd7, 1);  // R4 wrap 2048 bytes -> 2047
        put(1, 2'b01, 8'd255, 3'd7, 1);  // R6 max bytecnt 32768
        put(1, 2'b11, 8'd0,   3'd0, 1);  // R3 reserved code -> all ones
        put(1, 2'b10, 8'd1,   3'd0, 1);  // R4 wrap 2 bytes -> 1
        put(1, 2'b10, 8'd15,  3'd4, 0);  // R2 stall
        repeat (4) put(1, 2'b00, 8'd2, 3'd1, 0);
        put(0, 2'b00, 8'd0, 3'd0, 1);
        // random traffic with back-pressure
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] bt;
            logic [7:0] ln;
            bt = 2'($urandom);
            ln = (bt == 2'b10) ? 8'((2 << ($urandom % 4)) - 1) : 8'($urandom);
            put(1'($urandom % 3 != 0), bt, ln, 3'($urandom), (i % 200) > 150 ? 1'b0 : 1'($urandom % 4 != 0));
        end
        put(0, 2'b00, 8'd0, 3'd0, 1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule